// File: doc/BRIEF.md
# Software Write-Protect Command Detector

This block sits in front of the page write sequencer of a parallel EEPROM. It sees every byte write as a one-cycle strobe carrying a 15-bit address and an 8-bit data value. It tracks the short unlock sequences that software uses to control write protection, and it holds a flag that says whether protection is active. For each write it gives one verdict: either the byte goes on to the page sequencer, or it is discarded.

Protection is switched on by a three-write key. The key must be followed by at least one real data byte, and that byte is forwarded. Protection is switched off by a six-write key, and none of its bytes are forwarded. While protection is on, a page load is accepted only after the three-write key. Other writes are discarded. Key writes are never forwarded. A write that breaks a sequence sends the detector back to idle, and an unprotected break write is then treated as ordinary data. The page sequencer reports the end of a page load on a separate input.

Top module: `sdp_guard`

## Requirements
- R1: After reset, prot_on_o is 0, and wr_pass_o and wr_drop_o are both 0 until the first write.
- R2: Every cycle with wr_valid_i high gives exactly one of wr_pass_o or wr_drop_o high in the following cycle. A cycle with no write gives neither.
- R3: The key writes are data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. They are always dropped. Every write after them passes until page_done_i closes the page window.
- R4: prot_on_o goes to 1 on the clock edge that accepts the first data byte after the three-write key. If the key is followed directly by page_done_i, the protection state does not change.
- R5: While prot_on_o is 1, any write that is neither a key step nor inside an open page window is dropped.
- R6: The six writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555 are all dropped. prot_on_o stays at its previous value until the edge that accepts the sixth write, and is 0 after it.
- R7: A write that does not match the next expected step returns the detector to idle. If that write is 0xAA@0x5555, it is taken as step one of a new sequence and dropped. Otherwise it passes when protection is off.
- R8: Key matching compares all 15 address bits and all 8 data bits. 0xAA@0x5554 and 0xAB@0x5555 are not key writes.
- R9: A write in the same cycle as page_done_i is judged as if the page window were already closed. It does not change the protection state.
- R10: While protection is off and no sequence is in progress, a write that is not 0xAA@0x5555 passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | One-cycle write strobe |
| wr_addr_i | input | 15 | Write address |
| wr_data_i | input | 8 | Write data |
| page_done_i | input | 1 | Page load closed by the sequencer |
| wr_pass_o | output | 1 | Previous-cycle write forwarded |
| wr_drop_o | output | 1 | Previous-cycle write discarded |
| prot_on_o | output | 1 | Write protection active |

## Verification
The assertions assume that each write is a single-cycle strobe with stable address and data. They also assume that page_done_i is only meaningful while a page window is open. A page_done_i pulse at any other time must leave everything unchanged. The bench drives inputs on the falling edge, one write per cycle at most, and raises page_done_i only as a single-cycle pulse. The one deliberate exception is a page_done_i pulse that coincides with a write, used to test R9.

// File: rtl/sdp_guard_pkg.sv
package sdp_guard_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_OPEN, ST_X3, ST_X4, ST_X5
  } sdp_state_e;

  localparam int unsigned NUM_KEYS = 5;
  localparam int unsigned K_AA = 0;
  localparam int unsigned K_55 = 1;
  localparam int unsigned K_A0 = 2;
  localparam int unsigned K_80 = 3;
  localparam int unsigned K_20 = 4;
endpackage

// File: rtl/sdp_key_match.sv
module sdp_key_match
  import sdp_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_HI = 15'h5555,
  parameter logic [ADDR_W-1:0] ADDR_LO = 15'h2AAA,
  parameter logic [DATA_W-1:0] DAT_K1  = 8'hAA,
  parameter logic [DATA_W-1:0] DAT_K2  = 8'h55,
  parameter logic [DATA_W-1:0] DAT_EN  = 8'hA0,
  parameter logic [DATA_W-1:0] DAT_X   = 8'h80,
  parameter logic [DATA_W-1:0] DAT_OFF = 8'h20
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   data_i,
  output logic [NUM_KEYS-1:0] hit_o
);
  localparam logic [NUM_KEYS-1:0][ADDR_W-1:0] KEY_ADDR =
    {ADDR_HI, ADDR_HI, ADDR_HI, ADDR_LO, ADDR_HI};
  localparam logic [NUM_KEYS-1:0][DATA_W-1:0] KEY_DATA =
    {DAT_OFF, DAT_X, DAT_EN, DAT_K2, DAT_K1};

  // full-width compare per key code
  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_key
    assign hit_o[g] = (addr_i == KEY_ADDR[g]) && (data_i == KEY_DATA[g]);
  end
endmodule

// File: rtl/sdp_seq.sv
module sdp_seq
  import sdp_guard_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_valid_i,
  input  logic                page_done_i,
  input  logic [NUM_KEYS-1:0] hit_i,
  output logic                pass_o,
  output logic                prot_o
);
  sdp_state_e state_q, state_d, state_eff;
  logic       prot_q, prot_d;
  logic       step_hit;
  sdp_state_e step_nxt;

  // page_done closes the window before the same-cycle write is judged
  assign state_eff = (page_done_i && state_q == ST_OPEN) ? ST_IDLE : state_q;

  always_comb begin
    step_hit = 1'b0;
    step_nxt = ST_IDLE;
    unique case (state_eff)
      ST_IDLE: if (hit_i[K_AA]) begin step_hit = 1'b1; step_nxt = ST_K1; end
      ST_K1:   if (hit_i[K_55]) begin step_hit = 1'b1; step_nxt = ST_K2; end
      ST_K2: begin
        if (hit_i[K_A0]) begin step_hit = 1'b1; step_nxt = ST_OPEN; end
        else if (hit_i[K_80]) begin step_hit = 1'b1; step_nxt = ST_X3; end
      end
      ST_X3:   if (hit_i[K_AA]) begin step_hit = 1'b1; step_nxt = ST_X4; end
      ST_X4:   if (hit_i[K_55]) begin step_hit = 1'b1; step_nxt = ST_X5; end
      ST_X5:   if (hit_i[K_20]) begin step_hit = 1'b1; step_nxt = ST_IDLE; end
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_eff;
    prot_d  = prot_q;
    pass_o  = 1'b0;
    if (wr_valid_i) begin
      if (state_eff == ST_OPEN) begin
        pass_o = 1'b1;
        prot_d = 1'b1;
      end else if (step_hit) begin
        state_d = step_nxt;
        if (state_eff == ST_X5) prot_d = 1'b0;
      end else if (hit_i[K_AA]) begin
        state_d = ST_K1;
      end else begin
        state_d = ST_IDLE;
        pass_o  = !prot_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      prot_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      prot_q  <= prot_d;
    end
  end

  assign prot_o = prot_q;

  assert_prot_rise_from_open_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prot_q) |-> $past(state_q) == ST_OPEN);
  assert_key_never_forwarded_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && hit_i[K_AA] && state_eff != ST_OPEN) |-> !pass_o);
  assert_prot_fall_from_x5_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(prot_q) |-> $past(state_q) == ST_X5);
endmodule

// File: rtl/sdp_verdict.sv
module sdp_verdict (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_valid_i,
  input  logic pass_i,
  output logic wr_pass_o,
  output logic wr_drop_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_pass_o <= 1'b0;
      wr_drop_o <= 1'b0;
    end else begin
      wr_pass_o <= wr_valid_i && pass_i;
      wr_drop_o <= wr_valid_i && !pass_i;
    end
  end

  assert_one_verdict_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |=> (wr_pass_o ^ wr_drop_o));
  assert_quiet_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> !(wr_pass_o || wr_drop_o));
endmodule

// File: rtl/sdp_guard.sv
module sdp_guard
  import sdp_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_HI = 15'h5555,
  parameter logic [ADDR_W-1:0] ADDR_LO = 15'h2AAA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              page_done_i,
  output logic              wr_pass_o,
  output logic              wr_drop_o,
  output logic              prot_on_o
);
  logic [NUM_KEYS-1:0] hit;
  logic                pass;

  sdp_key_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO)
  ) i_match (
    .addr_i(wr_addr_i), .data_i(wr_data_i), .hit_o(hit)
  );

  sdp_seq i_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i),
    .page_done_i(page_done_i), .hit_i(hit), .pass_o(pass), .prot_o(prot_on_o)
  );

  sdp_verdict i_verdict (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i), .pass_i(pass),
    .wr_pass_o(wr_pass_o), .wr_drop_o(wr_drop_o)
  );

  assert_prot_on_with_pass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prot_on_o) |-> wr_pass_o);
  assert_prot_off_with_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(prot_on_o) |-> wr_drop_o);
endmodule

// File: tb/test_sdp_guard.sv
module test_sdp_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        page_done = 1'b0;
  logic        wr_pass, wr_drop, prot_on;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sdp_guard i_sdp_guard (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .page_done_i(page_done),
    .wr_pass_o(wr_pass), .wr_drop_o(wr_drop), .prot_on_o(prot_on)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // one write; verdict and protection sampled after the accepting edge
  task automatic wr(input logic [14:0] a, input logic [7:0] d, input logic pd,
                    input logic exp_pass, input logic exp_prot, input string tag);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; page_done = pd;
    @(posedge clk); #1;
    chk(wr_pass, exp_pass, {tag, " pass"});
    chk(wr_drop, !exp_pass, {tag, " drop"});
    chk(prot_on, exp_prot, {tag, " prot"});
    @(negedge clk);
    wr_valid = 1'b0; page_done = 1'b0;
  endtask

  task automatic close_page();
    @(negedge clk);
    page_done = 1'b1;
    @(negedge clk);
    page_done = 1'b0;
  endtask

  task automatic key3(input logic prot, input string tag);
    wr(15'h5555, 8'hAA, 1'b0, 1'b0, prot, tag);
    wr(15'h2AAA, 8'h55, 1'b0, 1'b0, prot, tag);
    wr(15'h5555, 8'hA0, 1'b0, 1'b0, prot, tag);
  endtask

  task automatic t_reset();
    #1;
    chk(prot_on, 1'b0, "R1 prot");
    chk(wr_pass, 1'b0, "R1 pass");
    chk(wr_drop, 1'b0, "R1 drop");
  endtask

  task automatic t_plain();
    wr(15'h0123, 8'h5A, 1'b0, 1'b1, 1'b0, "R10 plain");
    @(posedge clk); #1;
    chk(wr_pass || wr_drop, 1'b0, "R2 quiet");
  endtask

  task automatic t_prefix_only();
    key3(1'b0, "R3 key");
    close_page();
    @(posedge clk); #1;
    chk(prot_on, 1'b0, "R4 key alone");
  endtask

  task automatic t_enable();
    key3(1'b0, "R3 key");
    wr(15'h0100, 8'h11, 1'b0, 1'b1, 1'b1, "R4 first data");
    wr(15'h5555, 8'hAA, 1'b0, 1'b1, 1'b1, "R3 window data");
    close_page();
    wr(15'h0200, 8'h22, 1'b0, 1'b0, 1'b1, "R5 unkeyed");
    key3(1'b1, "R3 key on");
    wr(15'h0300, 8'h33, 1'b0, 1'b1, 1'b1, "R3 keyed data");
    close_page();
  endtask

  task automatic t_full_width();
    wr(15'h5554, 8'hAA, 1'b0, 1'b0, 1'b1, "R8 addr");
    wr(15'h2AAA, 8'h55, 1'b0, 1'b0, 1'b1, "R8 addr");
    wr(15'h5555, 8'hA0, 1'b0, 1'b0, 1'b1, "R8 addr");
    wr(15'h0400, 8'h44, 1'b0, 1'b0, 1'b1, "R8 no unlock a");
    wr(15'h5555, 8'hAB, 1'b0, 1'b0, 1'b1, "R8 data");
    wr(15'h2AAA, 8'h55, 1'b0, 1'b0, 1'b1, "R8 data");
    wr(15'h5555, 8'hA0, 1'b0, 1'b0, 1'b1, "R8 data");
    wr(15'h0400, 8'h45, 1'b0, 1'b0, 1'b1, "R8 no unlock d");
  endtask

  task automatic t_restart();
    wr(15'h5555, 8'hAA, 1'b0, 1'b0, 1'b1, "R7 first");
    wr(15'h5555, 8'hAA, 1'b0, 1'b0, 1'b1, "R7 restart");
    wr(15'h2AAA, 8'h55, 1'b0, 1'b0, 1'b1, "R7 step2");
    wr(15'h5555, 8'hA0, 1'b0, 1'b0, 1'b1, "R7 step3");
    wr(15'h0500, 8'h55, 1'b0, 1'b1, 1'b1, "R7 data");
    close_page();
  endtask

  task automatic t_disable();
    wr(15'h5555, 8'hAA, 1'b0, 1'b0, 1'b1, "R6 s1");
    wr(15'h2AAA, 8'h55, 1'b0, 1'b0, 1'b1, "R6 s2");
    wr(15'h5555, 8'h80, 1'b0, 1'b0, 1'b1, "R6 s3");
    wr(15'h5555, 8'hAA, 1'b0, 1'b0, 1'b1, "R6 s4");
    wr(15'h2AAA, 8'h55, 1'b0, 1'b0, 1'b1, "R6 s5");
    wr(15'h5555, 8'h20, 1'b0, 1'b0, 1'b0, "R6 s6");
    wr(15'h0600, 8'h66, 1'b0, 1'b1, 1'b0, "R10 after off");
  endtask

  task automatic t_break_unprot();
    wr(15'h5555, 8'hAA, 1'b0, 1'b0, 1'b0, "R7 start");
    wr(15'h0040, 8'h77, 1'b0, 1'b1, 1'b0, "R7 break passes");
    wr(15'h2AAA, 8'h55, 1'b0, 1'b1, 1'b0, "R7 idle step2 passes");
  endtask

  task automatic t_coincide();
    key3(1'b0, "R9 key");
    wr(15'h0700, 8'h70, 1'b1, 1'b1, 1'b0, "R9 same cycle");
    wr(15'h0701, 8'h71, 1'b0, 1'b1, 1'b0, "R9 after");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_plain();
    t_prefix_only();
    t_enable();
    t_full_width();
    t_restart();
    t_disable();
    t_break_unprot();
    t_coincide();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule